// File: doc/BRIEF.md
# Audio Serial Port Control and Status Register Bank

This block is the 32-bit register bank that software uses to control one audio serial port. It holds four registers: a control word that drives the port, a status word that collects FIFO events, a data word and a fixed identification word. Reads and writes arrive over a simple valid/write/address/data bus. Read data comes back one cycle after the request, flagged by a valid pulse.

Each writable register can be reached at three addresses. The base address replaces the whole word. The set alias at base+0x4 turns on every bit written as one. The clear alias at base+0x8 turns off every bit written as one. Software can therefore change single control bits without a read-modify-write.

FIFO underflow and overflow events arrive as single-cycle pulses. Each one latches a sticky status bit, which stays set until software writes a one to that bit through the status clear alias. A shared error interrupt is raised while the error enable is on and either sticky bit is set. The top two control bits are a soft reset and a clock gate, and both come up set. While the soft reset is set, the other control bits, the data word and the sticky flags are all held at their reset values.

Top module: `aport_csr`

## Requirements
- R1: After a reset with rst_n low, control reads 0xC000_0000 (bit 31 soft reset and bit 30 clock gate set), data reads 0, the status flags read 0 and err_irq is low.
- R2: A bus read returns its value on bus_rdata with bus_rvalid high in the cycle after the request. A write to the base address of control (0x00) or data (0x20) replaces the whole register.
- R3: A write to base+0x4 sets every register bit written as one and leaves the other bits unchanged.
- R4: A write to base+0x8 clears every register bit written as one and leaves the other bits unchanged.
- R5: While control bit 31 is set, control reads back as 0xC000_0000, the data register stays 0, and FIFO pulses leave the sticky flags at 0. Any write that leaves bit 31 set also yields 0xC000_0000.
- R6: A pulse on fifo_unf_pulse sets status bit 6, and a pulse on fifo_ovf_pulse sets status bit 5. Each bit stays set through writes to the status base (0x10) and set alias (0x14). It is cleared only by writing a one to that bit at 0x18. A pulse in the same cycle as the clear leaves the bit set.
- R7: Status bit 0 reads the fifo_busy input and status bit 4 reads the fifo_svc_req input, as sampled at the read request.
- R8: err_irq is high exactly when control bit 25 is set and at least one of status bits 6 or 5 is set.
- R9: svc_irq is high exactly when control bit 24 is set and fifo_svc_req is high.
- R10: Reads of the identification register (0x30 and its aliases) return the VERSION parameter. Writes to it change nothing.
- R11: An address with bits [1:0] nonzero or bits above 5 nonzero, or an alias offset of 0xC, reads 0 and is ignored on write.
- R12: The ctrl_word and data_word ports show the current control and data registers. Among the control bits, bit 0 is run, bit 1 selects receive (1) or transmit (0), and bit 2 selects slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| fifo_unf_pulse | input | 1 | FIFO underflow event pulse |
| fifo_ovf_pulse | input | 1 | FIFO overflow event pulse |
| fifo_svc_req | input | 1 | FIFO service request level |
| fifo_busy | input | 1 | Port busy level |
| ctrl_word | output | 32 | Current control register |
| data_word | output | 32 | Current data register |
| err_irq | output | 1 | FIFO error interrupt |
| svc_irq | output | 1 | FIFO service interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the default VERSION constant. The 8-bit address leaves room for out-of-range addresses such as 0x40, so the decode-rejection paths can be exercised next to the four mapped registers and their twelve alias slots. The directed tests cover soft-reset holding of every register, alias arithmetic on both writable words, and a FIFO pulse landing in the same cycle as its own clear.

// File: rtl/aport_csr_pkg.sv
// Package: shared types and layout constants for the audio port register bank.
// Assumes a 32-bit data path; the bit positions below are decoded by the
// port logic that consumes ctrl_word, so they are fixed.
package aport_csr_pkg;

    localparam int CSR_W = 32;

    // Register selector, taken from address bits [5:4]
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_VER  = 2'd3
    } csr_sel_e;

    // Access kind, taken from address bits [3:2]
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } csr_op_e;

    // Control bit positions
    localparam int CB_SOFT_RST = 31;
    localparam int CB_CLK_GATE = 30;
    localparam int CB_ERR_IEN  = 25;
    localparam int CB_SVC_IEN  = 24;
    localparam int CB_SLAVE    = 2;
    localparam int CB_RX_SEL   = 1;
    localparam int CB_RUN      = 0;

    // Status bit positions
    localparam int SB_UNF  = 6;
    localparam int SB_OVF  = 5;
    localparam int SB_SVC  = 4;
    localparam int SB_BUSY = 0;

    localparam logic [CSR_W-1:0] CTRL_RESET = 32'hC000_0000;
    localparam logic [CSR_W-1:0] DATA_RESET = 32'h0000_0000;

endpackage

// File: rtl/aport_alias_reg.sv
// Module: one register word with write, set-alias and clear-alias updates.
// Assumes at most one access per cycle. hold_i forces the reset value.
// When SELF_HOLD is set, a result whose top bit is 1 also collapses to the
// reset value, so the word's own top bit acts as a soft reset.
module aport_alias_reg
    import aport_csr_pkg::*;
#(
    parameter int              W         = 32,
    parameter logic [W-1:0]    RESET_VAL = '0,
    parameter bit              SELF_HOLD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic          wr_i,
    input  csr_op_e       op_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  q_o
);

    logic [W-1:0] q_r;
    logic [W-1:0] upd;
    logic [W-1:0] nxt;

    // Purpose: apply the access kind to the current value.
    always_comb begin
        upd = q_r;
        if (wr_i) begin
            unique case (op_i)
                OP_WRITE: upd = wdata_i;
                OP_SET:   upd = q_r | wdata_i;
                OP_CLR:   upd = q_r & ~wdata_i;
                default:  upd = q_r;
            endcase
        end
    end

    // Purpose: pick the self-hold variant chosen by the parameter.
    generate
        if (SELF_HOLD) begin : g_self
            assign nxt = upd[W-1] ? RESET_VAL : upd;
        end else begin : g_plain
            assign nxt = upd;
        end
    endgenerate

    // Purpose: register the word, with reset and external hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) q_r <= RESET_VAL;
        else                  q_r <= nxt;
    end

    assign q_o = q_r;

    // R3: a set write drops no bit that was already on
    a_r3_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && op_i == OP_SET && !hold_i &&
         !(SELF_HOLD && (q_r[W-1] || wdata_i[W-1])))
        |=> ((q_o & $past(q_o)) == $past(q_o)));

    // R4: a clear write leaves none of the written-one bits on
    a_r4_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && op_i == OP_CLR && !hold_i && !(SELF_HOLD && q_r[W-1]))
        |=> ((q_o & $past(wdata_i)) == '0));

endmodule

// File: rtl/aport_sticky_flags.sv
// Module: a bank of sticky event flags.
// Assumes events are single-cycle pulses. A pulse wins over a clear in the
// same cycle, so no event is lost. hold_i keeps every flag at 0.
module aport_sticky_flags #(
    parameter int N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic [N-1:0]  evt_i,
    input  logic [N-1:0]  clr_i,
    output logic [N-1:0]  flag_o
);

    logic [N-1:0] flag_r;

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            // Purpose: latch the event, drop on clear, event has priority.
            always_ff @(posedge clk) begin
                if (!rst_n || hold_i) flag_r[i] <= 1'b0;
                else if (evt_i[i])    flag_r[i] <= 1'b1;
                else if (clr_i[i])    flag_r[i] <= 1'b0;
            end

            // R6: a set flag survives any cycle without its clear
            a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_o[i] && !clr_i[i] && !hold_i) |=> flag_o[i]);

            // R6: a pulse always leaves the flag set (clear cannot beat it)
            a_r6_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_i[i] && !hold_i) |=> flag_o[i]);

            // R5: soft reset keeps the flag low
            a_r5_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
                hold_i |=> !flag_o[i]);
        end
    endgenerate

    assign flag_o = flag_r;

endmodule

// File: rtl/aport_csr.sv
// Module: audio serial port register bank (top).
// Decodes a simple valid/write bus into four registers at 0x00, 0x10, 0x20
// and 0x30, each with a set alias (+0x4) and a clear alias (+0x8).
// Assumes one access per cycle. Read data is registered and returned
// one cycle after the request.
module aport_csr
    import aport_csr_pkg::*;
#(
    parameter int               ADDR_W  = 8,
    parameter logic [31:0]      VERSION = 32'h0001_0203
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic               fifo_unf_pulse,
    input  logic               fifo_ovf_pulse,
    input  logic               fifo_svc_req,
    input  logic               fifo_busy,
    output logic [31:0]        ctrl_word,
    output logic [31:0]        data_word,
    output logic               err_irq,
    output logic               svc_irq
);

    localparam int MAP_BITS = 6;                 // 4 registers x 4 slots x 4 bytes
    localparam int HI_W     = ADDR_W - MAP_BITS;
    localparam int NFLAG    = 2;                 // [1] underflow, [0] overflow

    logic              hit;
    csr_sel_e          sel;
    csr_op_e           op;
    logic              wr_any;
    logic              ctrl_wr;
    logic              data_wr;
    logic [NFLAG-1:0]  flag_clr;
    logic [NFLAG-1:0]  flag_evt;
    logic [NFLAG-1:0]  flags;
    logic [31:0]       ctrl_q;
    logic [31:0]       data_q;
    logic [31:0]       stat_view;
    logic [31:0]       rd_mux;
    logic              soft_rst;

    // Purpose: decode the address into a register selector and access kind.
    always_comb begin
        hit = bus_valid && (bus_addr[ADDR_W-1:MAP_BITS] == HI_W'(0))
                        && (bus_addr[1:0] == 2'b00)
                        && (csr_op_e'(bus_addr[3:2]) != OP_NONE);
        sel = csr_sel_e'(bus_addr[5:4]);
        op  = csr_op_e'(bus_addr[3:2]);
    end

    // Purpose: route write strobes to the register that owns the address.
    always_comb begin
        wr_any   = hit && bus_write;
        ctrl_wr  = wr_any && (sel == SEL_CTRL);
        data_wr  = wr_any && (sel == SEL_DATA);
        flag_clr = '0;
        if (wr_any && sel == SEL_STAT && op == OP_CLR)
            flag_clr = {bus_wdata[SB_UNF], bus_wdata[SB_OVF]};
    end

    aport_alias_reg #(
        .W         (32),
        .RESET_VAL (CTRL_RESET),
        .SELF_HOLD (1'b1)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (1'b0),
        .wr_i    (ctrl_wr),
        .op_i    (op),
        .wdata_i (bus_wdata),
        .q_o     (ctrl_q)
    );

    assign soft_rst = ctrl_q[CB_SOFT_RST];

    aport_alias_reg #(
        .W         (32),
        .RESET_VAL (DATA_RESET),
        .SELF_HOLD (1'b0)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (soft_rst),
        .wr_i    (data_wr),
        .op_i    (op),
        .wdata_i (bus_wdata),
        .q_o     (data_q)
    );

    assign flag_evt = {fifo_unf_pulse, fifo_ovf_pulse};

    aport_sticky_flags #(
        .N (NFLAG)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (soft_rst),
        .evt_i  (flag_evt),
        .clr_i  (flag_clr),
        .flag_o (flags)
    );

    // Purpose: assemble the status word from sticky flags and live levels.
    always_comb begin
        stat_view          = '0;
        stat_view[SB_UNF]  = flags[1];
        stat_view[SB_OVF]  = flags[0];
        stat_view[SB_SVC]  = fifo_svc_req;
        stat_view[SB_BUSY] = fifo_busy;
    end

    // Purpose: select the read value for the addressed register.
    always_comb begin
        rd_mux = '0;
        if (hit) begin
            unique case (sel)
                SEL_CTRL: rd_mux = ctrl_q;
                SEL_STAT: rd_mux = stat_view;
                SEL_DATA: rd_mux = data_q;
                default:  rd_mux = VERSION;
            endcase
        end
    end

    // Purpose: register read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rdata  <= rd_mux;
            bus_rvalid <= bus_valid && !bus_write;
        end
    end

    // Purpose: drive interrupts and register mirrors.
    assign err_irq   = ctrl_q[CB_ERR_IEN] && (flags != '0);
    assign svc_irq   = ctrl_q[CB_SVC_IEN] && fifo_svc_req;
    assign ctrl_word = ctrl_q;
    assign data_word = data_q;

    // R2: every read request is answered in the next cycle
    a_r2_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    // R5: soft reset pins the control word to its reset pattern
    a_r5_ctrl_held: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[CB_SOFT_RST] |-> (ctrl_word == CTRL_RESET));

    // R8: the error interrupt needs its enable
    a_r8_err_irq_en: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> ctrl_word[CB_ERR_IEN]);

    // R10: identification reads return the constant
    a_r10_version: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == ADDR_W'(8'h30)) |=> (bus_rdata == VERSION));

    // R11: an out-of-range read returns zero
    a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr[1:0] != 2'b00) |=> (bus_rdata == 32'h0));

endmodule

// File: tb/aport_csr_tb.sv
module aport_csr_tb;

    localparam int          ADDR_W = 8;
    localparam logic [31:0] VER    = 32'h0001_0203;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              fifo_unf_pulse = 1'b0;
    logic              fifo_ovf_pulse = 1'b0;
    logic              fifo_svc_req = 1'b0;
    logic              fifo_busy = 1'b0;
    logic [31:0]       ctrl_word;
    logic [31:0]       data_word;
    logic              err_irq;
    logic              svc_irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    aport_csr #(.ADDR_W(ADDR_W), .VERSION(VER)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .fifo_unf_pulse(fifo_unf_pulse), .fifo_ovf_pulse(fifo_ovf_pulse),
        .fifo_svc_req(fifo_svc_req), .fifo_busy(fifo_busy),
        .ctrl_word(ctrl_word), .data_word(data_word),
        .err_irq(err_irq), .svc_irq(svc_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    // Drive at negedge; the register updates at the next posedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Read: data is registered at the posedge and sampled at the next negedge.
    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check({req, " rvalid"}, {31'b0, bus_rvalid}, 32'd1);
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse_unf();
        @(negedge clk); fifo_unf_pulse = 1'b1;
        @(negedge clk); fifo_unf_pulse = 1'b0;
    endtask

    task automatic pulse_ovf();
        @(negedge clk); fifo_ovf_pulse = 1'b1;
        @(negedge clk); fifo_ovf_pulse = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 8'h00, 32'hC000_0000);
        rd_chk("R1 data", 8'h20, 32'h0);
        rd_chk("R1 stat", 8'h10, 32'h0);
        check("R1 err_irq", {31'b0, err_irq}, 32'd0);
    endtask

    task automatic t_soft_hold();
        wr(8'h04, 32'h0000_0003);
        rd_chk("R5 ctrl set ignored", 8'h00, 32'hC000_0000);
        wr(8'h20, 32'h0000_0055);
        rd_chk("R5 data held", 8'h20, 32'h0);
        pulse_unf();
        rd_chk("R5 flag held", 8'h10, 32'h0);
        wr(8'h08, 32'hC000_0000);
        rd_chk("R4 release", 8'h00, 32'h0);
        wr(8'h00, 32'h8000_00FF);
        rd_chk("R5 write with bit31", 8'h00, 32'hC000_0000);
        wr(8'h00, 32'h0);
        rd_chk("R2 ctrl released", 8'h00, 32'h0);
    endtask

    task automatic t_write_read();
        wr(8'h00, 32'h0000_0007);
        rd_chk("R2 ctrl write", 8'h00, 32'h0000_0007);
        check("R12 ctrl_word run/rx/slave", ctrl_word, 32'h0000_0007);
        wr(8'h20, 32'hA5A5_5A5A);
        rd_chk("R2 data write", 8'h20, 32'hA5A5_5A5A);
        check("R12 data_word", data_word, 32'hA5A5_5A5A);
    endtask

    task automatic t_set_alias();
        wr(8'h04, 32'h0300_0000);
        rd_chk("R3 ctrl set", 8'h00, 32'h0300_0007);
        wr(8'h24, 32'h0000_00F0);
        rd_chk("R3 data set", 8'h20, 32'hA5A5_5AFA);
    endtask

    task automatic t_clr_alias();
        wr(8'h08, 32'h0000_0005);
        rd_chk("R4 ctrl clr", 8'h00, 32'h0300_0002);
        check("R12 rx only", ctrl_word, 32'h0300_0002);
        wr(8'h28, 32'hFFFF_0000);
        rd_chk("R4 data clr", 8'h20, 32'h0000_5AFA);
    endtask

    task automatic t_sticky();
        pulse_unf();
        rd_chk("R6 unf set", 8'h10, 32'h0000_0040);
        check("R8 err_irq on", {31'b0, err_irq}, 32'd1);
        wr(8'h10, 32'h0);
        rd_chk("R6 base write ignored", 8'h10, 32'h0000_0040);
        wr(8'h14, 32'h0000_0020);
        rd_chk("R6 set alias ignored", 8'h10, 32'h0000_0040);
        wr(8'h18, 32'h0000_0020);
        rd_chk("R6 other clr", 8'h10, 32'h0000_0040);
        wr(8'h18, 32'h0000_0040);
        rd_chk("R6 unf cleared", 8'h10, 32'h0);
        check("R8 err_irq off", {31'b0, err_irq}, 32'd0);
        // overflow pulse in the same cycle as its clear
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0000_0020;
        fifo_ovf_pulse = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; fifo_ovf_pulse = 1'b0;
        rd_chk("R6 pulse beats clear", 8'h10, 32'h0000_0020);
        check("R8 err_irq ovf", {31'b0, err_irq}, 32'd1);
        wr(8'h08, 32'h0200_0000);
        check("R8 err_irq disabled", {31'b0, err_irq}, 32'd0);
        rd_chk("R6 ovf kept", 8'h10, 32'h0000_0020);
        wr(8'h18, 32'h0000_0060);
        rd_chk("R6 all clear", 8'h10, 32'h0);
        pulse_ovf();
        check("R8 enable off ovf", {31'b0, err_irq}, 32'd0);
        wr(8'h18, 32'h0000_0020);
    endtask

    task automatic t_live();
        @(negedge clk);
        fifo_busy = 1'b1; fifo_svc_req = 1'b1;
        rd_chk("R7 busy+svc", 8'h10, 32'h0000_0011);
        check("R9 svc_irq on", {31'b0, svc_irq}, 32'd1);
        wr(8'h08, 32'h0100_0000);
        check("R9 svc_irq off", {31'b0, svc_irq}, 32'd0);
        @(negedge clk);
        fifo_busy = 1'b0; fifo_svc_req = 1'b0;
        rd_chk("R7 idle", 8'h10, 32'h0);
    endtask

    task automatic t_version();
        rd_chk("R10 ver", 8'h30, VER);
        wr(8'h30, 32'hDEAD_BEEF);
        rd_chk("R10 ver after write", 8'h30, VER);
        wr(8'h38, 32'hFFFF_FFFF);
        rd_chk("R10 ver alias", 8'h34, VER);
    endtask

    task automatic t_unmapped();
        rd_chk("R11 high addr", 8'h40, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        rd_chk("R11 ctrl untouched", 8'h00, 32'h0000_0002);
        rd_chk("R11 slot 0xC", 8'h0C, 32'h0);
        rd_chk("R11 misaligned", 8'h21, 32'h0);
        rd_chk("R11 data untouched", 8'h20, 32'h0000_5AFA);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_soft_hold();
        t_write_read();
        t_set_alias();
        t_clr_alias();
        t_sticky();
        t_live();
        t_version();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule